// File: doc/BRIEF.md
# PCI Exclusive-Access Lock Tracker

This block follows the PCI resource-lock protocol on behalf of a bridge or target. It watches a simplified transaction interface: a strobe for the address phase, the address, the command nibble, the direction of travel, the identity of the initiator now on the bus, the sampled lock signal, the frame signal, and the outcome of each transaction. From these it decides when an initiator has taken exclusive ownership of a 16-byte aligned memory region, how long that ownership lasts, and when it ends.

While a lock is held, the block answers a new access to the locked region from any initiator other than the owner with a same-cycle retry request. All other traffic, including traffic from other initiators to other addresses, goes through untouched. A separate output tells the write path to stop posting writes for as long as a locked operation is being set up or is active. Bus grant plays no part: ownership is recorded only from the lock handshake. A configuration input turns the whole feature on or off.

Top module: `xlock_tracker`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears lock_held, lock_base and post_disable to 0 on that edge, whatever state the lock was in. retry_req is 0 while no lock is held.
- R2: A lock is set up when, with cfg_lock_en high, an address phase (addr_strobe high) carries the memory read command 4'b0110, txn_downstream high and lock_in low, lock_in is high in the next cycle, and the transaction then finishes with txn_done high and txn_fail low. lock_held rises on the edge that samples txn_done, and lock_base then holds txn_addr[31:4] from that address phase.
- R3: If txn_fail is sampled high before txn_done during the setup, no lock is recorded: lock_held stays 0 and post_disable returns to 0 on the next edge.
- R4: An address phase with txn_downstream low never starts a lock, whatever the command and lock_in.
- R5: With cfg_lock_en low, lock_in is ignored and no lock is set up; dropping cfg_lock_en while a lock is held releases it on the next edge.
- R6: An address phase carrying any command other than 4'b0110 (for example memory write 4'b0111) never starts a lock.
- R7: While a lock is held, an address phase from an initiator whose init_id differs from the owner's, to any address whose bits [31:4] equal lock_base, raises retry_req in that same cycle, whatever its low four address bits.
- R8: While a lock is held, an address phase to an address outside the locked 16-byte region raises no retry_req, whoever issues it.
- R9: While a lock is held, an address phase from the owner to the locked region raises no retry_req.
- R10: A retried access has no other effect: lock_held stays 1 and lock_base is unchanged afterwards.
- R11: post_disable is high from the edge after a qualifying address phase, through the whole hold, up to the release edge.
- R12: A held lock is released only when lock_in and frame_act are both sampled low at the same edge; lock_held, lock_base and post_disable are 0 after that edge. lock_in low with frame_act high does not release it.
- R13: If lock_in is still low in the cycle after the qualifying address phase, or is already high during the address phase, no lock is set up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lock_en | input | 1 | Enables lock tracking |
| addr_strobe | input | 1 | High for the address phase of a transaction |
| frame_act | input | 1 | Frame signal, high while a transaction is on the bus |
| txn_addr | input | ADDR_W (32) | Address of the address phase |
| txn_cmd | input | 4 | Bus command of the address phase |
| txn_downstream | input | 1 | High when the transaction travels away from the processor |
| init_id | input | ID_W (3) | Identity of the initiator now on the bus |
| lock_in | input | 1 | Sampled lock signal, high when asserted |
| txn_done | input | 1 | Transaction finished normally |
| txn_fail | input | 1 | Transaction was retried or aborted |
| lock_held | output | 1 | A locked region is active |
| lock_base | output | ADDR_W-GRAN_BITS (28) | Base of the locked region, address bits [31:4] |
| retry_req | output | 1 | Retry the current access, which hits another initiator's lock |
| post_disable | output | 1 | Suppress write posting |

## Verification
The hardest states to reach are the narrow windows inside the setup handshake: the single cycle after the address phase, where lock_in must rise, and the waiting period before completion, where a retry or abort must undo everything. The bench drives these phases one cycle at a time, putting in a failure, a missing lock assertion or a disabled feature at each step and checking post_disable and lock_held after every edge. The release rule is exercised with a non-owner transaction that holds frame_act high while lock_in is low, so a release that looks at lock_in alone is caught.

// File: rtl/xlock_pkg.sv
package xlock_pkg;

   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_ARM  = 2'd1,
      LK_PEND = 2'd2,
      LK_HELD = 2'd3
   } lk_state_e;

   localparam logic [3:0] CMD_MEM_READ = 4'b0110;

endpackage

// File: rtl/xlock_region_cmp.sv
module xlock_region_cmp #(
   parameter int ADDR_W    = 32,
   parameter int GRAN_BITS = 4,
   parameter int ID_W      = 3,
   localparam int BASE_W   = ADDR_W - GRAN_BITS
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BASE_W-1:0] base,
   input  logic [ID_W-1:0]   id,
   input  logic [ID_W-1:0]   owner,
   output logic [BASE_W-1:0] region_of,
   output logic              in_region,
   output logic              is_owner
);

   generate
      if (GRAN_BITS == 0) begin : g_full
         assign region_of = addr;
      end else begin : g_slice
         logic unused_low;
         assign region_of  = addr[ADDR_W-1:GRAN_BITS];
         assign unused_low = ^addr[GRAN_BITS-1:0];
      end
   endgenerate

   assign in_region = (region_of == base);
   assign is_owner  = (id == owner);

endmodule

// File: rtl/xlock_ctrl.sv
module xlock_ctrl
   import xlock_pkg::*;
#(
   parameter int BASE_W = 28,
   parameter int ID_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_en,
   input  logic              addr_strobe,
   input  logic              frame_act,
   input  logic [3:0]        cmd,
   input  logic              downstream,
   input  logic              lock_in,
   input  logic              txn_done,
   input  logic              txn_fail,
   input  logic [BASE_W-1:0] addr_base,
   input  logic [ID_W-1:0]   id,
   output logic [BASE_W-1:0] base_q,
   output logic [ID_W-1:0]   owner_q,
   output logic              held,
   output logic              busy
);

   lk_state_e state_q, state_d;
   logic      start_ok;
   logic      capture;
   logic      clear;

   assign start_ok = lock_en && addr_strobe && downstream &&
                     (cmd == CMD_MEM_READ) && !lock_in;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LK_IDLE: if (start_ok) state_d = LK_ARM;
         LK_ARM: begin
            if (!lock_en || txn_fail || !lock_in) state_d = LK_IDLE;
            else if (txn_done)                    state_d = LK_HELD;
            else                                  state_d = LK_PEND;
         end
         LK_PEND: begin
            if (!lock_en || txn_fail) state_d = LK_IDLE;
            else if (txn_done)        state_d = LK_HELD;
         end
         LK_HELD: if (!lock_en || (!lock_in && !frame_act)) state_d = LK_IDLE;
         default: state_d = LK_IDLE;
      endcase
   end

   assign capture = (state_q == LK_IDLE) && start_ok;
   assign clear   = (state_q != LK_IDLE) && (state_d == LK_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LK_IDLE;
         base_q  <= '0;
         owner_q <= '0;
      end else begin
         state_q <= state_d;
         if (capture) begin
            base_q  <= addr_base;
            owner_q <= id;
         end else if (clear) begin
            base_q  <= '0;
            owner_q <= '0;
         end
      end
   end

   assign held = (state_q == LK_HELD);
   assign busy = (state_q != LK_IDLE);

endmodule

// File: rtl/xlock_tracker.sv
module xlock_tracker #(
   parameter int ADDR_W    = 32,
   parameter int GRAN_BITS = 4,
   parameter int ID_W      = 3,
   localparam int BASE_W   = ADDR_W - GRAN_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_lock_en,
   input  logic              addr_strobe,
   input  logic              frame_act,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic [3:0]        txn_cmd,
   input  logic              txn_downstream,
   input  logic [ID_W-1:0]   init_id,
   input  logic              lock_in,
   input  logic              txn_done,
   input  logic              txn_fail,
   output logic              lock_held,
   output logic [BASE_W-1:0] lock_base,
   output logic              retry_req,
   output logic              post_disable
);

   generate
      if (GRAN_BITS < 0 || GRAN_BITS >= ADDR_W) begin : g_bad_gran
         $error("xlock_tracker: GRAN_BITS must lie in 0..ADDR_W-1");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("xlock_tracker: ID_W must be at least 1");
      end
   endgenerate

   logic [BASE_W-1:0] cur_base;
   logic [BASE_W-1:0] base_q;
   logic [ID_W-1:0]   owner_q;
   logic              hit_region;
   logic              hit_owner;
   logic              held;
   logic              busy;

   xlock_region_cmp #(
      .ADDR_W    (ADDR_W),
      .GRAN_BITS (GRAN_BITS),
      .ID_W      (ID_W)
   ) u_cmp (
      .addr      (txn_addr),
      .base      (base_q),
      .id        (init_id),
      .owner     (owner_q),
      .region_of (cur_base),
      .in_region (hit_region),
      .is_owner  (hit_owner)
   );

   xlock_ctrl #(
      .BASE_W (BASE_W),
      .ID_W   (ID_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .lock_en     (cfg_lock_en),
      .addr_strobe (addr_strobe),
      .frame_act   (frame_act),
      .cmd         (txn_cmd),
      .downstream  (txn_downstream),
      .lock_in     (lock_in),
      .txn_done    (txn_done),
      .txn_fail    (txn_fail),
      .addr_base   (cur_base),
      .id          (init_id),
      .base_q      (base_q),
      .owner_q     (owner_q),
      .held        (held),
      .busy        (busy)
   );

   assign lock_held    = held;
   assign lock_base    = held ? base_q : '0;
   assign retry_req    = held && addr_strobe && hit_region && !hit_owner;
   assign post_disable = busy;

endmodule

// File: rtl/xlock_tracker_chk.sv
module xlock_tracker_chk #(
   parameter int BASE_W = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_lock_en,
   input logic              addr_strobe,
   input logic              frame_act,
   input logic [3:0]        txn_cmd,
   input logic              txn_downstream,
   input logic              lock_in,
   input logic              lock_held,
   input logic [BASE_W-1:0] lock_base,
   input logic              retry_req,
   input logic              post_disable
);

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (!lock_held && !post_disable && lock_base == '0));

   // R7
   retry_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> (lock_held && addr_strobe));

   // R11
   posting_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_held |-> post_disable);

   // R12
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_held && !lock_in && !frame_act) |=> !lock_held);

   // R12
   no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_held && cfg_lock_en && frame_act) |=> lock_held);

   // R5
   disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_lock_en |=> !post_disable);

   // R4
   upstream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!post_disable && addr_strobe && !txn_downstream) |=> !post_disable);

   // R6
   wrong_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!post_disable && addr_strobe && txn_cmd != 4'b0110) |=> !post_disable);

   // R10
   base_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_held |=> (!lock_held || $stable(lock_base)));

endmodule

bind xlock_tracker xlock_tracker_chk #(
   .BASE_W (BASE_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_lock_en    (cfg_lock_en),
   .addr_strobe    (addr_strobe),
   .frame_act      (frame_act),
   .txn_cmd        (txn_cmd),
   .txn_downstream (txn_downstream),
   .lock_in        (lock_in),
   .lock_held      (lock_held),
   .lock_base      (lock_base),
   .retry_req      (retry_req),
   .post_disable   (post_disable)
);

// File: tb/xlock_tracker_tb.sv
`timescale 1ns/1ps
module xlock_tracker_tb;

   localparam int ADDR_W = 32;
   localparam int GRAN   = 4;
   localparam int ID_W   = 3;
   localparam int BW     = ADDR_W - GRAN;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cfg_lock_en;
   logic              addr_strobe;
   logic              frame_act;
   logic [ADDR_W-1:0] txn_addr;
   logic [3:0]        txn_cmd;
   logic              txn_downstream;
   logic [ID_W-1:0]   init_id;
   logic              lock_in;
   logic              txn_done;
   logic              txn_fail;
   logic              lock_held;
   logic [BW-1:0]     lock_base;
   logic              retry_req;
   logic              post_disable;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   xlock_tracker #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN), .ID_W(ID_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_lock_en(cfg_lock_en),
      .addr_strobe(addr_strobe), .frame_act(frame_act), .txn_addr(txn_addr),
      .txn_cmd(txn_cmd), .txn_downstream(txn_downstream), .init_id(init_id),
      .lock_in(lock_in), .txn_done(txn_done), .txn_fail(txn_fail),
      .lock_held(lock_held), .lock_base(lock_base), .retry_req(retry_req),
      .post_disable(post_disable)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic bus_idle();
      addr_strobe = 1'b0; frame_act = 1'b0; txn_addr = '0; txn_cmd = 4'h0;
      init_id = '0; lock_in = 1'b0; txn_done = 1'b0; txn_fail = 1'b0;
      txn_downstream = 1'b1;
   endtask

   task automatic addr_phase(input logic [31:0] a, input logic [ID_W-1:0] id,
                             input logic [3:0] c, input logic down, input logic lk);
      addr_strobe = 1'b1; frame_act = 1'b1; txn_addr = a; init_id = id;
      txn_cmd = c; txn_downstream = down; lock_in = lk;
      txn_done = 1'b0; txn_fail = 1'b0;
   endtask

   // full setup handshake; ends with lock held and an idle bus, lock_in high
   task automatic acquire(input logic [31:0] a, input logic [ID_W-1:0] id);
      addr_phase(a, id, 4'b0110, 1'b1, 1'b0);
      tick();
      addr_strobe = 1'b0; lock_in = 1'b1;
      tick();
      txn_done = 1'b1;
      tick();
      txn_done = 1'b0; frame_act = 1'b0;
   endtask

   task automatic release_lock();
      bus_idle();
      tick();
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cfg_lock_en = 1'b1; bus_idle();
      tick(); tick();
      check("R1 held after reset", lock_held, 0);
      check("R1 base after reset", lock_base, 0);
      check("R1 post after reset", post_disable, 0);
      check("R1 retry after reset", retry_req, 0);
      rst_n = 1'b1;
      tick();
      acquire(32'hCAFE_0010, 3'd1);
      tick();
      check("R1 lock held before reset", lock_held, 1);
      rst_n = 1'b0;
      tick();
      check("R1 mid-lock reset clears held", lock_held, 0);
      check("R1 mid-lock reset clears post", post_disable, 0);
      check("R1 mid-lock reset clears base", lock_base, 0);
      rst_n = 1'b1; bus_idle();
      tick();
   endtask

   task automatic t_acquire_release();
      addr_phase(32'h1234_5678, 3'd2, 4'b0110, 1'b1, 1'b0);
      tick();
      check("R11 posting off after address phase", post_disable, 1);
      check("R2 not held during setup", lock_held, 0);
      addr_strobe = 1'b0; lock_in = 1'b1;
      tick();
      check("R2 not held before completion", lock_held, 0);
      txn_done = 1'b1;
      tick();
      check("R2 held after completion", lock_held, 1);
      check("R2 base is addr[31:4]", lock_base, 32'h0123_4567);
      txn_done = 1'b0; frame_act = 1'b0;
      tick();
      check("R11 posting off while held", post_disable, 1);
      // another initiator's transaction: lock_in low, frame high
      addr_phase(32'h0000_1000, 3'd4, 4'b0111, 1'b1, 1'b0);
      tick();
      addr_strobe = 1'b0;
      tick();
      check("R12 no release while frame high", lock_held, 1);
      release_lock();
      check("R12 released", lock_held, 0);
      check("R12 base cleared", lock_base, 0);
      check("R12 posting back on", post_disable, 0);
   endtask

   task automatic t_conflict();
      acquire(32'h1234_5678, 3'd2);
      tick();
      addr_phase(32'h1234_567C, 3'd5, 4'b0111, 1'b1, 1'b1);
      #1;
      check("R7 retry non-owner hit", retry_req, 1);
      txn_addr = 32'h1234_5670;
      #1;
      check("R7 retry at region start", retry_req, 1);
      txn_addr = 32'h1234_5680;
      #1;
      check("R8 no retry outside region", retry_req, 0);
      txn_addr = 32'h1234_5660;
      #1;
      check("R8 no retry below region", retry_req, 0);
      txn_addr = 32'h1234_5674; init_id = 3'd2;
      #1;
      check("R9 owner not retried", retry_req, 0);
      txn_addr = 32'h1234_5678; init_id = 3'd6; txn_fail = 1'b1;
      #1;
      check("R7 retry second non-owner", retry_req, 1);
      tick();
      addr_strobe = 1'b0; txn_fail = 1'b0; frame_act = 1'b0; lock_in = 1'b1;
      tick();
      check("R10 still held after retry", lock_held, 1);
      check("R10 base unchanged after retry", lock_base, 32'h0123_4567);
      release_lock();
      check("R12 released after conflict", lock_held, 0);
   endtask

   task automatic t_setup_failure();
      addr_phase(32'h0000_0040, 3'd3, 4'b0110, 1'b1, 1'b0);
      tick();
      addr_strobe = 1'b0; lock_in = 1'b1;
      tick();
      check("R11 posting off while waiting", post_disable, 1);
      txn_fail = 1'b1;
      tick();
      check("R3 no lock after retry", lock_held, 0);
      check("R3 posting restored", post_disable, 0);
      bus_idle();
      tick();
      // abort in the cycle right after the address phase
      addr_phase(32'h0000_0040, 3'd3, 4'b0110, 1'b1, 1'b0);
      tick();
      addr_strobe = 1'b0; lock_in = 1'b1; txn_fail = 1'b1;
      tick();
      check("R3 no lock after early abort", post_disable, 0);
      bus_idle();
      tick();
   endtask

   task automatic t_no_followup();
      addr_phase(32'h0000_0080, 3'd1, 4'b0110, 1'b1, 1'b0);
      tick();
      addr_strobe = 1'b0; lock_in = 1'b0;
      tick();
      check("R13 lock_in stays low cancels", post_disable, 0);
      txn_done = 1'b1; lock_in = 1'b1;
      tick();
      check("R13 no lock", lock_held, 0);
      bus_idle();
      tick();
      addr_phase(32'h0000_0080, 3'd1, 4'b0110, 1'b1, 1'b1);
      tick();
      check("R13 lock already high ignored", post_disable, 0);
      bus_idle();
      tick();
   endtask

   task automatic t_upstream_cmd();
      addr_phase(32'h0000_0100, 3'd1, 4'b0110, 1'b0, 1'b0);
      tick();
      check("R4 upstream no setup", post_disable, 0);
      addr_strobe = 1'b0; lock_in = 1'b1;
      tick();
      txn_done = 1'b1;
      tick();
      check("R4 upstream no lock", lock_held, 0);
      bus_idle();
      tick();
      addr_phase(32'h0000_0100, 3'd1, 4'b0111, 1'b1, 1'b0);
      tick();
      check("R6 write no setup", post_disable, 0);
      addr_strobe = 1'b0; lock_in = 1'b1;
      tick();
      txn_done = 1'b1;
      tick();
      check("R6 write no lock", lock_held, 0);
      bus_idle();
      tick();
   endtask

   task automatic t_disabled();
      cfg_lock_en = 1'b0;
      acquire(32'h0000_0200, 3'd2);
      tick();
      check("R5 disabled no lock", lock_held, 0);
      check("R5 disabled posting on", post_disable, 0);
      bus_idle();
      cfg_lock_en = 1'b1;
      tick();
      acquire(32'h0000_0200, 3'd2);
      tick();
      check("R5 enabled lock held", lock_held, 1);
      cfg_lock_en = 1'b0;
      tick();
      check("R5 disable drops lock", lock_held, 0);
      check("R5 disable restores posting", post_disable, 0);
      cfg_lock_en = 1'b1;
      bus_idle();
      tick();
   endtask

   initial begin
      t_reset();
      t_acquire_release();
      t_conflict();
      t_setup_failure();
      t_no_followup();
      t_upstream_cmd();
      t_disabled();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule